// File: doc/BRIEF.md
# Counted Transfer Sequence Observer

A synthesizable runtime checker that follows a two-phase counted handshake on five single-bit control lines. A trigger pulse opens a collection window. Inside that window a fixed number of acquire pulses must arrive, with any number of idle cycles between them, and the abort line must stay low throughout. Once that count is reached, the transfer is committed. From the next cycle on, the same number of deliver pulses must arrive before the finish line is raised. A finish that comes too early is flagged as a violation.

The block tracks one transaction at a time. A trigger that arrives while a transaction is open is ignored. An aborted or completed transaction returns the observer to idle with no report. The check is a safety check: an obligation still open when observation stops is never reported. A violation raises a one-cycle pulse and a sticky flag, and the observer goes back to idle. The phase of the observer is visible as a two-bit code. All inputs are plain level signals sampled on each rising clock edge, so there is no stream interface and no back-pressure.

Top module: `xfer_seq_watch`

## Requirements
- R1: After reset, phase_o is 0, viol_pulse_o is 0 and viol_sticky_o is 0.
- R2: phase_o encodes 0 idle, 1 collecting acquires, 2 collecting delivers. A begin_i seen in idle moves phase_o to 1 on the next cycle. take_i, abort_i and finish_i in that same cycle have no effect.
- R3: In phase 1, XFER_COUNT take_i pulses with no abort_i move phase_o to 2 on the cycle after the last pulse. The pulses may have gaps between them, and finish_i in phase 1 raises no violation.
- R4: abort_i in phase 1 returns phase_o to 0 on the next cycle with no violation. This holds even in the cycle of the final take_i.
- R5: In phase 2, finish_i raises a violation when it comes before the XFER_COUNT-th give_i, and also when it comes in the same cycle as that give_i.
- R6: In phase 2, XFER_COUNT give_i pulses without finish_i return phase_o to 0 on the cycle after the last one, with no violation. A later finish_i has no effect.
- R7: A violation drives viol_pulse_o high for exactly the next cycle and sets viol_sticky_o, which stays high until reset. phase_o is 0 in that same cycle.
- R8: begin_i in phase 1 or phase 2 is ignored, and the counting already in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| begin_i | input | 1 | Trigger that opens a transaction |
| take_i | input | 1 | Acquire pulse, counted in phase 1 |
| abort_i | input | 1 | Cancels the transaction while in phase 1 |
| give_i | input | 1 | Deliver pulse, counted in phase 2 |
| finish_i | input | 1 | Finish marker, forbidden in phase 2 |
| viol_sticky_o | output | 1 | Violation seen since reset |
| viol_pulse_o | output | 1 | One-cycle violation pulse |
| phase_o | output | 2 | Observer phase code |

## Verification
A wrong acquire count shows up as phase_o reaching 2 one or more cycles early or late, so every take_i in the bench is checked on the cycle after it. A wrong deliver count either flags a legal finish, or misses an early one in the cycle after that finish. A lost abort leaves phase_o at 1 on the cycle after abort_i, and a re-armed trigger moves the commit point of the ongoing transaction. Both are visible within one cycle at phase_o.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TAKE = 2'd1,
    PH_GIVE = 2'd2
  } phase_e;
endpackage

// File: rtl/xsw_pulse_count.sv
module xsw_pulse_count #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign last_o = inc_i && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + W'(1);
  end

  // R3: the running count never reaches the limit itself
  assert_count_below_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < W'(LIMIT));
endmodule

// File: rtl/xsw_phase_fsm.sv
module xsw_phase_fsm
  import xsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       begin_i,
  input  logic       take_i,
  input  logic       abort_i,
  input  logic       give_i,
  input  logic       finish_i,
  input  logic       take_last_i,
  input  logic       give_last_i,
  output logic       take_clr_o,
  output logic       take_inc_o,
  output logic       give_clr_o,
  output logic       give_inc_o,
  output logic       viol_o,
  output logic [1:0] phase_o
);
  phase_e state_q, state_d;

  always_comb begin
    take_clr_o = (state_q != PH_TAKE);
    take_inc_o = (state_q == PH_TAKE) && take_i && !abort_i;
    give_clr_o = (state_q != PH_GIVE);
    give_inc_o = (state_q == PH_GIVE) && give_i && !finish_i;
    viol_o     = (state_q == PH_GIVE) && finish_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (begin_i) state_d = PH_TAKE;
      PH_TAKE: begin
        if (abort_i)          state_d = PH_IDLE;
        else if (take_last_i) state_d = PH_GIVE;
      end
      PH_GIVE: begin
        if (finish_i)         state_d = PH_IDLE;
        else if (give_last_i) state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign phase_o = state_q;

  // R2: only the three defined phase codes appear
  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o != 2'd3);
endmodule

// File: rtl/xsw_viol_flag.sv
module xsw_viol_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_i,
  output logic pulse_o,
  output logic sticky_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o  <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      pulse_o  <= viol_i;
      sticky_o <= sticky_o | viol_i;
    end
  end

  assert_sticky_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_o |=> sticky_o);
  assert_pulse_sets_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> sticky_o);
  assert_pulse_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/xfer_seq_watch.sv
module xfer_seq_watch
  import xsw_pkg::*;
#(
  parameter int XFER_COUNT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       begin_i,
  input  logic       take_i,
  input  logic       abort_i,
  input  logic       give_i,
  input  logic       finish_i,
  output logic       viol_sticky_o,
  output logic       viol_pulse_o,
  output logic [1:0] phase_o
);
  localparam int NCNT = 2;

  logic [NCNT-1:0] cnt_clr, cnt_inc, cnt_last;
  logic            viol;

  xsw_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .begin_i    (begin_i),
    .take_i     (take_i),
    .abort_i    (abort_i),
    .give_i     (give_i),
    .finish_i   (finish_i),
    .take_last_i(cnt_last[0]),
    .give_last_i(cnt_last[1]),
    .take_clr_o (cnt_clr[0]),
    .take_inc_o (cnt_inc[0]),
    .give_clr_o (cnt_clr[1]),
    .give_inc_o (cnt_inc[1]),
    .viol_o     (viol),
    .phase_o    (phase_o)
  );

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    xsw_pulse_count #(.LIMIT(XFER_COUNT)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr[k]),
      .inc_i (cnt_inc[k]),
      .last_o(cnt_last[k])
    );
  end

  xsw_viol_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .viol_i  (viol),
    .pulse_o (viol_pulse_o),
    .sticky_o(viol_sticky_o)
  );

  assert_abort_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_TAKE && abort_i) |=> (phase_o == PH_IDLE && !viol_pulse_o));
  assert_early_finish_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_GIVE && finish_i) |=> viol_pulse_o);
  assert_violation_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse_o |-> (phase_o == PH_IDLE));
  assert_begin_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_TAKE && begin_i && !take_i && !abort_i) |=> (phase_o == PH_TAKE));
endmodule

// File: tb/test_xfer_seq_watch.sv
module test_xfer_seq_watch;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic begin_i = 0, take_i = 0, abort_i = 0, give_i = 0, finish_i = 0;
  logic viol_sticky_o, viol_pulse_o;
  logic [1:0] phase_o;

  int checks = 0;
  int failures = 0;
  logic exp_stk = 1'b0;

  typedef struct {
    logic [1:0] ph;
    logic       pl;
    logic       st;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  xfer_seq_watch #(.XFER_COUNT(N)) i_xfer_seq_watch (
    .clk(clk), .rst_n(rst_n), .begin_i(begin_i), .take_i(take_i),
    .abort_i(abort_i), .give_i(give_i), .finish_i(finish_i),
    .viol_sticky_o(viol_sticky_o), .viol_pulse_o(viol_pulse_o), .phase_o(phase_o)
  );

  // monitor: compares each expected item 5 ns after the edge that produced it
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (phase_o !== e.ph || viol_pulse_o !== e.pl || viol_sticky_o !== e.st) begin
        failures++;
        $display("FAIL %s: phase/pulse/sticky actual %0d/%0b/%0b expected %0d/%0b/%0b",
                 e.tag, phase_o, viol_pulse_o, viol_sticky_o, e.ph, e.pl, e.st);
      end
    end
  end

  // driver: one cycle of stimulus plus the outputs expected after the next edge
  task automatic step(input logic b, input logic t, input logic a, input logic g,
                      input logic f, input logic [1:0] ph, input logic pl, input string tag);
    exp_t x;
    @(negedge clk);
    begin_i = b; take_i = t; abort_i = a; give_i = g; finish_i = f;
    if (pl) exp_stk = 1'b1;
    x.ph = ph; x.pl = pl; x.st = exp_stk; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input logic [1:0] ph, input string tag);
    step(0, 0, 0, 0, 0, ph, 0, tag);
  endtask

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk);
    begin_i = 0; take_i = 0; abort_i = 0; give_i = 0; finish_i = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_stk = 1'b0;
    #1;
    checks++;
    if (phase_o !== 2'd0 || viol_pulse_o !== 1'b0 || viol_sticky_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 R7 reset: phase/pulse/sticky actual %0d/%0b/%0b expected 0/0/0",
               phase_o, viol_pulse_o, viol_sticky_o);
    end
  endtask

  // commit a transaction: begin then N takes, ending in phase 2
  task automatic commit(input string tag);
    step(1, 0, 0, 0, 0, 2'd1, 0, tag);
    for (int i = 0; i < N; i++) step(0, 1, 0, 0, 0, (i == N-1) ? 2'd2 : 2'd1, 0, tag);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    do_reset();  // R1

    // R2, R3, R6: begin with stray take/abort, gapped takes, finish during takes
    step(1, 1, 1, 0, 0, 2'd1, 0, "R2 begin");
    for (int i = 0; i < N; i++) begin
      step(0, 1, 0, 0, (i == 2), (i == N-1) ? 2'd2 : 2'd1, 0, "R3 take");
      if (i < N-1) for (int j = 0; j < (i % 3); j++) idle(2'd1, "R3 gap");
    end
    for (int i = 0; i < N; i++) begin
      step(0, 0, 0, 1, 0, (i == N-1) ? 2'd0 : 2'd2, 0, "R6 give");
      if (i < N-1 && i[0]) idle(2'd2, "R6 gap");
    end
    step(0, 0, 0, 0, 1, 2'd0, 0, "R6 late finish");
    idle(2'd0, "R6 quiet");

    // R4: abort midway, and abort together with the final take
    step(1, 0, 0, 0, 0, 2'd1, 0, "R4 begin");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 2'd1, 0, "R4 take");
    step(0, 0, 1, 0, 0, 2'd0, 0, "R4 abort");
    step(1, 0, 0, 0, 0, 2'd1, 0, "R4 begin2");
    for (int i = 0; i < N-1; i++) step(0, 1, 0, 0, 0, 2'd1, 0, "R4 take2");
    step(0, 1, 1, 0, 0, 2'd0, 0, "R4 abort on last take");
    idle(2'd0, "R4 quiet");

    // R8: begin inside both phases does not restart counting
    step(1, 0, 0, 0, 0, 2'd1, 0, "R8 begin");
    step(0, 1, 0, 0, 0, 2'd1, 0, "R8 take");
    step(0, 1, 0, 0, 0, 2'd1, 0, "R8 take");
    step(1, 1, 0, 0, 0, 2'd1, 0, "R8 begin with take");
    for (int i = 3; i < N; i++) step(0, 1, 0, 0, 0, (i == N-1) ? 2'd2 : 2'd1, 0, "R8 take");
    for (int i = 0; i < N; i++) step((i == 4), 0, 0, 1, 0, (i == N-1) ? 2'd0 : 2'd2, 0, "R8 give");
    idle(2'd0, "R8 quiet");

    // R5, R7: early finish
    commit("R5 commit");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 2'd2, 0, "R5 give");
    step(0, 0, 0, 0, 1, 2'd0, 1, "R5 early finish");
    idle(2'd0, "R7 pulse drops, sticky holds");
    step(0, 0, 0, 0, 1, 2'd0, 0, "R7 finish in idle");
    idle(2'd0, "R7 sticky holds");

    do_reset();  // R7: sticky cleared only by reset

    // R5: finish in the cycle of the final give
    commit("R5 commit2");
    for (int i = 0; i < N-1; i++) step(0, 0, 0, 1, 0, 2'd2, 0, "R5 give2");
    step(0, 0, 0, 1, 1, 2'd0, 1, "R5 finish with last give");
    idle(2'd0, "R7 back to idle");

    // R5: finish on the first cycle of phase 2
    commit("R5 commit3");
    step(0, 0, 0, 0, 1, 2'd0, 1, "R5 immediate finish");
    idle(2'd0, "R7 quiet");

    wait (q.size() == 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule